// File: doc/BRIEF.md
# Voice PCM Frame-Sync Serial Port

This block links a parallel voice-sample interface to an 8 kHz frame-synchronous serial bus. Each frame it takes one 13-bit two's-complement transmit sample, shifts it out most significant bit first on a serial data line, and collects one 13-bit two's-complement receive sample from a serial input. The transmit output carries an enable that models a tri-state pad driver. The enable is active only while sample bits are on the line.

The serial pins are asynchronous to the system clock. They pass through synchronizer stages and are edge-detected in the system clock domain. Two frame-sync formats are supported. With the short format, a one-bit-period pulse announces the frame. With the long format, the rising frame sync itself marks the first bit. In the two plain 13-bit modes, the receive pins have their own bit clock and frame sync, and these need not be related to the transmit ones.

Two 16-bit synchronous modes drive both directions from the transmit bit clock and frame sync. The sign-extended mode places three extra copies of the sign bit ahead of the 13-bit word, in both directions. The gain-adjust mode keeps transmit at 13 bits. Its receive frame carries 13 voice bits followed by a 3-bit attenuation code. The code is reported both raw and scaled to decibels.

Top module: `pcm_frame_port`

## Requirements
- R1: Transmit bits are launched MSB first, one per rising edge of the transmit bit clock. With the short format, the first bit is launched at the rising edge after the one at which frame sync was sampled high.
- R2: With the long format, the first transmit bit is launched at the rising bit-clock edge where frame sync is first seen high after having been low at the previous rising edge.
- R3: `tx_data_oe` is 1 only during the bit periods of a transfer (13 or 16 of them). It is 0 in idle periods and from the rising edge after the last bit.
- R4: The transmit sample is captured once per frame at the start edge, and `tx_take` pulses once at that point. A change to `tx_sample` during a transfer does not alter the bits sent.
- R5: In plain mode (`xfer_mode` = 00), 13 receive bits are sampled MSB first on falling edges of the active bit clock. After the last bit, `rx_valid` pulses for one cycle with the word on `rx_sample` and `rx_code` = 000.
- R6: In plain mode, the receive side runs from `rx_bclk` and `rx_fs`, at a rate and phase independent of the transmit side.
- R7: In sign-extended mode (`xfer_mode` = 01), both directions use `tx_bclk` and `tx_fs` with 16-bit transfers. Transmit sends three copies of the sign bit and then the 13-bit sample. Receive reports the last 13 of the 16 bits.
- R8: In gain-adjust mode (`xfer_mode` = 10), both directions use `tx_bclk` and `tx_fs`. Transmit sends 13 bits. Receive takes 16 bits: 13 voice bits first, then the 3-bit code, MSB first. In every other mode `rx_code` reads 000 at `rx_valid`.
- R9: `rx_atten_db` equals three times `rx_code`, so 000 gives 0 dB and 111 gives 21 dB.
- R10: After reset, `tx_data_oe`, `tx_data`, `rx_valid`, `rx_sample`, `rx_code` and `rx_atten_db` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than either bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_mode | input | 2 | 00 plain, 01 sign-extended 16-bit, 10 gain-adjust, 11 treated as plain |
| long_fs | input | 1 | 1 selects long frame-sync timing, 0 short |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fs | input | 1 | Transmit frame sync |
| tx_data | output | 1 | Serial transmit data |
| tx_data_oe | output | 1 | Pad-driver enable for `tx_data` |
| tx_sample | input | 13 | Parallel transmit sample, two's complement |
| tx_take | output | 1 | One-cycle pulse when `tx_sample` is captured |
| rx_bclk | input | 1 | Receive bit clock (plain mode only) |
| rx_fs | input | 1 | Receive frame sync (plain mode only) |
| rx_data | input | 1 | Serial receive data |
| rx_sample | output | 13 | Last received sample, two's complement |
| rx_code | output | 3 | Last received attenuation code |
| rx_atten_db | output | 5 | Attenuation in dB, three times `rx_code` |
| rx_valid | output | 1 | One-cycle pulse when a receive frame completes |

## Verification
The bench uses the default parameters: 13-bit samples, a 3-bit code and two synchronizer stages. With these, the 16-bit word and the 0 to 21 dB range match the intended bus. The transmit bit clock runs with 10-cycle half periods and the receive bit clock with 7-cycle half periods. Plain-mode frames therefore overlap with unrelated phase, which tests the independent receive side. The sample patterns include the most negative and most positive values and all eight attenuation codes, so the sign copies and the code field are both exercised at their extremes.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef enum logic [1:0] {
    XM_PLAIN   = 2'b00,
    XM_SIGNEXT = 2'b01,
    XM_GAIN    = 2'b10,
    XM_RSVD    = 2'b11
  } xfer_mode_e;

  function automatic logic is_sync_mode(input xfer_mode_e m);
    return (m == XM_SIGNEXT) || (m == XM_GAIN);
  endfunction

endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pcm_frame_det.sv
module pcm_frame_det (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fs,
  input  logic long_fs,
  output logic rise,
  output logic fall,
  output logic start
);

  logic bclk_q;
  logic fs_r1_q, fs_r1_d;
  logic fs_r2_q, fs_r2_d;

  assign rise = bclk & ~bclk_q;
  assign fall = ~bclk & bclk_q;

  // short: fs seen at the previous rising edge only; long: fs rises now
  assign start = rise & (long_fs ? (fs & ~fs_r1_q) : (fs_r1_q & ~fs_r2_q));

  always_comb begin
    fs_r1_d = fs_r1_q;
    fs_r2_d = fs_r2_q;
    if (rise) begin
      fs_r1_d = fs;
      fs_r2_d = fs_r1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      fs_r1_q <= 1'b0;
      fs_r2_q <= 1'b0;
    end else begin
      bclk_q  <= bclk;
      fs_r1_q <= fs_r1_d;
      fs_r2_q <= fs_r2_d;
    end
  end

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_port_pkg::*;
#(
  parameter int SAMPLE_W = 13,
  parameter int CODE_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  xfer_mode_e          mode,
  input  logic                rise,
  input  logic                start,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                dout,
  output logic                oe,
  output logic                take
);

  localparam int WORD_W = SAMPLE_W + CODE_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] word_al;
  logic [CNT_W-1:0]  len;

  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              oe_q, oe_d;
  logic              dout_q, dout_d;
  logic              take_q, take_d;

  always_comb begin
    if (mode == XM_SIGNEXT) begin
      word_al = {{CODE_W{sample[SAMPLE_W-1]}}, sample};
      len     = CNT_W'(WORD_W);
    end else begin
      word_al = {sample, {CODE_W{1'b0}}};
      len     = CNT_W'(SAMPLE_W);
    end
  end

  always_comb begin
    shreg_d = shreg_q;
    left_d  = left_q;
    oe_d    = oe_q;
    dout_d  = dout_q;
    take_d  = 1'b0;
    if (rise) begin
      if (start) begin
        dout_d  = word_al[WORD_W-1];
        shreg_d = word_al << 1;
        left_d  = len - CNT_W'(1);
        oe_d    = 1'b1;
        take_d  = 1'b1;
      end else if (oe_q && (left_q != '0)) begin
        dout_d  = shreg_q[WORD_W-1];
        shreg_d = shreg_q << 1;
        left_d  = left_q - CNT_W'(1);
      end else if (oe_q) begin
        oe_d   = 1'b0;
        dout_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      left_q  <= '0;
      oe_q    <= 1'b0;
      dout_q  <= 1'b0;
      take_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      left_q  <= left_d;
      oe_q    <= oe_d;
      dout_q  <= dout_d;
      take_q  <= take_d;
    end
  end

  assign dout = dout_q;
  assign oe   = oe_q;
  assign take = take_q;

  // R1: a frame start always turns the driver on and captures the sample
  assert_start_launches_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (oe_q && take_q));

  // R1: serial data and enable only move on a rising bit-clock edge
  assert_launch_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> ($stable(dout_q) && $stable(oe_q)));

  // R3: the driver never turns on without a frame start
  assert_oe_only_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_q && !start) |=> !oe_q);

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_port_pkg::*;
#(
  parameter int SAMPLE_W = 13,
  parameter int CODE_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  xfer_mode_e          mode,
  input  logic                rise,
  input  logic                fall,
  input  logic                start,
  input  logic                din,
  output logic                valid,
  output logic [SAMPLE_W-1:0] sample,
  output logic [CODE_W-1:0]   code
);

  localparam int WORD_W = SAMPLE_W + CODE_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic [CNT_W-1:0]  len;
  logic [WORD_W-1:0] word_nx;

  logic [WORD_W-1:0]   shreg_q, shreg_d;
  logic [CNT_W-1:0]    left_q, left_d;
  logic                busy_q, busy_d;
  logic                valid_q, valid_d;
  logic [SAMPLE_W-1:0] sample_q, sample_d;
  logic [CODE_W-1:0]   code_q, code_d;

  assign len     = (mode == XM_SIGNEXT || mode == XM_GAIN) ? CNT_W'(WORD_W) : CNT_W'(SAMPLE_W);
  assign word_nx = {shreg_q[WORD_W-2:0], din};

  always_comb begin
    shreg_d  = shreg_q;
    left_d   = left_q;
    busy_d   = busy_q;
    valid_d  = 1'b0;
    sample_d = sample_q;
    code_d   = code_q;
    if (rise && start) begin
      busy_d  = 1'b1;
      left_d  = len;
      shreg_d = '0;
    end else if (fall && busy_q) begin
      shreg_d = word_nx;
      left_d  = left_q - CNT_W'(1);
      if (left_q == CNT_W'(1)) begin
        busy_d  = 1'b0;
        valid_d = 1'b1;
        if (mode == XM_GAIN) begin
          sample_d = word_nx[WORD_W-1:CODE_W];
          code_d   = word_nx[CODE_W-1:0];
        end else begin
          sample_d = word_nx[SAMPLE_W-1:0];
          code_d   = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      left_q   <= '0;
      busy_q   <= 1'b0;
      valid_q  <= 1'b0;
      sample_q <= '0;
      code_q   <= '0;
    end else begin
      shreg_q  <= shreg_d;
      left_q   <= left_d;
      busy_q   <= busy_d;
      valid_q  <= valid_d;
      sample_q <= sample_d;
      code_q   <= code_d;
    end
  end

  assign valid  = valid_q;
  assign sample = sample_q;
  assign code   = code_q;

  // R5: completion is a single-cycle pulse
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R5: a word completes only on the cycle after a falling bit-clock edge
  assert_capture_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(fall));

endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port
  import pcm_port_pkg::*;
#(
  parameter int SAMPLE_W    = 13,
  parameter int CODE_W      = 3,
  parameter int STEP_DB     = 3,
  parameter int SYNC_STAGES = 2,
  localparam int DB_W       = $clog2(STEP_DB * ((1 << CODE_W) - 1) + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          xfer_mode,
  input  logic                long_fs,
  input  logic                tx_bclk,
  input  logic                tx_fs,
  output logic                tx_data,
  output logic                tx_data_oe,
  input  logic [SAMPLE_W-1:0] tx_sample,
  output logic                tx_take,
  input  logic                rx_bclk,
  input  logic                rx_fs,
  input  logic                rx_data,
  output logic [SAMPLE_W-1:0] rx_sample,
  output logic [CODE_W-1:0]   rx_code,
  output logic [DB_W-1:0]     rx_atten_db,
  output logic                rx_valid
);

  xfer_mode_e mode;
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  assign mode = xfer_mode_e'(xfer_mode);

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  logic [4:0] pins_raw, pins_s;
  logic       txb_s, txf_s, rxb_s, rxf_s, rxd_s;

  assign pins_raw = {tx_bclk, tx_fs, rx_bclk, rx_fs, rx_data};
  assign {txb_s, txf_s, rxb_s, rxf_s, rxd_s} = pins_s;

  pcm_in_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_ni),
    .d     (pins_raw),
    .q     (pins_s)
  );

  logic t_rise, t_fall, t_start;
  logic r_rise, r_fall, r_start;

  pcm_frame_det u_tx_det (
    .clk     (clk),
    .rst_n   (rst_ni),
    .bclk    (txb_s),
    .fs      (txf_s),
    .long_fs (long_fs),
    .rise    (t_rise),
    .fall    (t_fall),
    .start   (t_start)
  );

  pcm_frame_det u_rx_det (
    .clk     (clk),
    .rst_n   (rst_ni),
    .bclk    (rxb_s),
    .fs      (rxf_s),
    .long_fs (long_fs),
    .rise    (r_rise),
    .fall    (r_fall),
    .start   (r_start)
  );

  // synchronous modes clock the receive lane from the transmit pins
  logic rx_sel_tx;
  logic l_rise, l_fall, l_start;

  assign rx_sel_tx = is_sync_mode(mode);
  assign l_rise    = rx_sel_tx ? t_rise  : r_rise;
  assign l_fall    = rx_sel_tx ? t_fall  : r_fall;
  assign l_start   = rx_sel_tx ? t_start : r_start;

  pcm_tx_lane #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_tx (
    .clk    (clk),
    .rst_n  (rst_ni),
    .mode   (mode),
    .rise   (t_rise),
    .start  (t_start),
    .sample (tx_sample),
    .dout   (tx_data),
    .oe     (tx_data_oe),
    .take   (tx_take)
  );

  pcm_rx_lane #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_ni),
    .mode   (mode),
    .rise   (l_rise),
    .fall   (l_fall),
    .start  (l_start),
    .din    (rxd_s),
    .valid  (rx_valid),
    .sample (rx_sample),
    .code   (rx_code)
  );

  assign rx_atten_db = DB_W'(int'(rx_code) * STEP_DB);

  // R8: only the gain-adjust frame carries a non-zero code
  assert_code_only_gain_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_valid && (mode != XM_GAIN)) |-> (rx_code == '0));

endmodule

// File: tb/sim_pcm_frame_port.sv
`timescale 1ns/1ps
module sim_pcm_frame_port;

  localparam int H_TX = 10;
  localparam int H_RX = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  xfer_mode;
  logic        long_fs;
  logic        tx_bclk, tx_fs, rx_bclk, rx_fs, rx_data;
  logic        tx_data, tx_data_oe, tx_take, rx_valid;
  logic [12:0] tx_sample, rx_sample;
  logic [2:0]  rx_code;
  logic [4:0]  rx_atten_db;

  int checks = 0;
  int errors = 0;
  int take_cnt = 0;
  logic [15:0] rx_q[$];
  logic [15:0] tx_q[$];

  always #5 clk = ~clk;

  pcm_frame_port u0 (
    .clk(clk), .rst_n(rst_n), .xfer_mode(xfer_mode), .long_fs(long_fs),
    .tx_bclk(tx_bclk), .tx_fs(tx_fs), .tx_data(tx_data), .tx_data_oe(tx_data_oe),
    .tx_sample(tx_sample), .tx_take(tx_take),
    .rx_bclk(rx_bclk), .rx_fs(rx_fs), .rx_data(rx_data),
    .rx_sample(rx_sample), .rx_code(rx_code), .rx_atten_db(rx_atten_db),
    .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: receive scoreboard
  always @(negedge clk) begin
    if (tx_take) take_cnt++;
    if (rst_n && rx_valid) begin
      if (rx_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected rx_valid", 1, 0);
      end else begin
        logic [15:0] e;
        e = rx_q.pop_front();
        chk(rx_sample == e[15:3], "R5", "rx_sample", rx_sample, e[15:3]);
        chk(rx_code == e[2:0], "R8", "rx_code", rx_code, e[2:0]);
        chk(rx_atten_db == 5'(e[2:0] * 3), "R9", "rx_atten_db", rx_atten_db, e[2:0] * 3);
      end
    end
  end

  // transmit-side frame; also feeds receive data in synchronous modes
  task automatic tx_frame(input logic [12:0] s, input logic [12:0] s_late,
                          input logic [15:0] rxw);
    int d0, tlen, p, t0;
    bit oe_ok, sync_m;
    logic [15:0] exp_w, got, e;
    sync_m = (xfer_mode == 2'b01) || (xfer_mode == 2'b10);
    d0 = long_fs ? 1 : 2;
    if (xfer_mode == 2'b01) begin exp_w = {{3{s[12]}}, s}; tlen = 16; end
    else begin exp_w = {3'b000, s}; tlen = 13; end
    tx_q.push_back(exp_w);
    if (xfer_mode == 2'b01) rx_q.push_back({rxw[12:0], 3'b000});
    else if (xfer_mode == 2'b10) rx_q.push_back(rxw);
    p = d0 + 16 + 3;
    got = '0;
    oe_ok = 1'b1;
    t0 = take_cnt;
    tx_sample = s;
    for (int k = 0; k < p; k++) begin
      tx_bclk = 1'b1;
      if (sync_m && k >= d0 && k < d0 + 16) rx_data = rxw[15 - (k - d0)];
      if (k == d0 + 3) tx_sample = s_late;
      wait_cyc(H_TX);
      if (k >= d0 && k < d0 + tlen) begin
        got = {got[14:0], tx_data};
        if (!tx_data_oe) oe_ok = 1'b0;
      end
      if (k == 0) chk(tx_data_oe == 1'b0, "R3", "oe before frame", tx_data_oe, 0);
      if (k == d0 + tlen) chk(tx_data_oe == 1'b0, "R3", "oe after last bit", tx_data_oe, 0);
      tx_bclk = 1'b0;
      if (k == 0) tx_fs = 1'b1;
      if (k == (long_fs ? 8 : 1)) tx_fs = 1'b0;
      wait_cyc(H_TX);
    end
    chk(oe_ok, "R3", "oe during bits", oe_ok, 1);
    e = tx_q.pop_front();
    chk(got == e, long_fs ? "R2" : "R1", "tx word", got, e);
    chk(take_cnt - t0 == 1, "R4", "tx_take pulses", take_cnt - t0, 1);
  endtask

  // independent receive-side frame for plain mode
  task automatic rx_frame(input logic [12:0] s);
    int d0, p;
    d0 = long_fs ? 1 : 2;
    rx_q.push_back({s, 3'b000});
    p = d0 + 13 + 3;
    for (int k = 0; k < p; k++) begin
      rx_bclk = 1'b1;
      if (k >= d0 && k < d0 + 13) rx_data = s[12 - (k - d0)];
      wait_cyc(H_RX);
      rx_bclk = 1'b0;
      if (k == 0) rx_fs = 1'b1;
      if (k == (long_fs ? 6 : 1)) rx_fs = 1'b0;
      wait_cyc(H_RX);
    end
  endtask

  task automatic drain();
    wait_cyc(20);
    chk(rx_q.size() == 0, "R6", "rx frames outstanding", rx_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; xfer_mode = 2'b00; long_fs = 1'b0;
    tx_bclk = 1'b0; tx_fs = 1'b0; rx_bclk = 1'b0; rx_fs = 1'b0; rx_data = 1'b0;
    tx_sample = '0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(10);
    // R10 reset state
    chk(tx_data_oe == 1'b0, "R10", "tx_data_oe", tx_data_oe, 0);
    chk(tx_data == 1'b0, "R10", "tx_data", tx_data, 0);
    chk(rx_valid == 1'b0, "R10", "rx_valid", rx_valid, 0);
    chk(rx_sample == '0, "R10", "rx_sample", rx_sample, 0);
    chk(rx_code == '0 && rx_atten_db == '0, "R10", "rx_code/db", rx_atten_db, 0);

    // R1 R4 R5 R6: plain, short sync, async sides running together
    fork
      begin tx_frame(13'h1A5C, 13'h0333, 16'h0); tx_frame(13'h1000, 13'h0FFF, 16'h0); end
      begin rx_frame(13'h0B71); rx_frame(13'h0FFF); rx_frame(13'h1000); end
    join
    drain();

    // R2 R6: plain, long sync
    long_fs = 1'b1;
    fork
      begin tx_frame(13'h0FFF, 13'h1000, 16'h0); tx_frame(13'h0001, 13'h1FFE, 16'h0); end
      begin rx_frame(13'h1FFF); rx_frame(13'h0001); rx_frame(13'h1555); end
    join
    drain();

    // R7: sign-extended, both sync formats
    xfer_mode = 2'b01;
    long_fs = 1'b0;
    tx_frame(13'h1234, 13'h0000, {3'b111, 13'h1234});
    tx_frame(13'h0ABC, 13'h1FFF, {3'b000, 13'h0ABC});
    long_fs = 1'b1;
    tx_frame(13'h1000, 13'h0001, {3'b111, 13'h1000});
    drain();

    // R8 R9: gain-adjust, every attenuation code
    xfer_mode = 2'b10;
    for (int c = 0; c < 8; c++) begin
      long_fs = c[0];
      tx_frame(13'(c * 13'h0321 + 13'h1003), 13'h0AAA, {13'(13'h1C35 ^ (c * 97)), 3'(c)});
    end
    drain();
    chk(rx_atten_db == 5'd21, "R9", "code 111 dB", rx_atten_db, 21);

    finish_run();
  end

endmodule